// File: doc/BRIEF.md
# Pad Configuration Write Gate with Group Mode Switching

This block decides, pad by pad, whether host software may change a pad's configuration. Each pad has a 4-bit owner field, a host-mode bit, and two lock bits: a full lock and a transmit lock. From these the block derives a usable flag for every pad. It holds the two 32-bit configuration words of each pad. A write from the bus to a pad that is not usable is dropped and flagged.

It also carries out group mode changes. A request names a list of pads and one 4-bit function mode. A small sequencer first checks that every listed pad is usable, one pad per cycle. Only if all of them pass does it rewrite the mode field of each pad, again one pad per cycle, and leave every other bit unchanged. If any pad fails the check, the sequencer rejects the request and changes nothing. Mode zero selects plain GPIO function. It also turns off interrupt routing, enables the receiver and disables the driver, so the pad starts as an input.

All register addresses are byte addresses on a 12-bit bus. Writes are synchronous and reads are combinational. With the default parameters there are 24 pads in groups of 16, so the second group is partial, and a request can list up to 4 pads.

Top module: `pad_access_gate`

## Requirements
- R1: The owner field of pad p sits at byte address 0x100 + 0x10*(p/G) + 4*((p%G)/8), in bits 4*(p%8)+3 down to 4*(p%8), where G is the group size. It is writable and reads back.
- R2: The full-lock bit of pad p is bit p%G of the word at 0x300 + 8*(p/G), and the transmit-lock bit is the same bit of the word 4 bytes higher. The host-mode bit is bit p%G of the word at 0x200 + 4*(p/G). All of these read back, and the host-mode bit has no effect on the usable flag.
- R3: A pad is usable exactly when its owner field is zero and both of its lock bits are clear. After reset, every field and every configuration word is zero, so every pad is usable.
- R4: The first configuration word of pad p is at 0x400 + 8*p and the second is at 4 bytes higher. A write to a usable pad stores the data, and a read returns it.
- R5: A configuration write to a pad that is not usable leaves both of its words unchanged. It raises the error output in the next cycle only, for one cycle.
- R6: A group request is rejected with no pad modified in any of these cases: a listed pad is not usable, a listed pad index is at or beyond the pad count, or the count exceeds the list capacity.
- R7: An accepted request sets bits 13:10 of each listed pad's first word to the requested mode and keeps all the other bits of that word.
- R8: When the requested mode is zero, each listed pad also has bits 20:17 cleared and bit 9 cleared, and has bit 8 set.
- R9: A request with a count of zero is accepted at once and changes nothing. The done output lasts exactly one cycle. A request raised while the sequencer is busy is ignored.
- R10: Done is counted from the clock edge that takes the request. An accepted request of n pads raises done 2n cycles later. A request rejected at list position k (counting from zero) raises done k+1 cycles later. A request rejected for its count raises done right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Write byte address |
| bus_wdata | input | 32 | Write data |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| cfg_err | output | 1 | One-cycle pulse: a configuration write hit an unusable pad |
| pad_usable | output | NUM_PADS | Per-pad usable flag |
| req_valid | input | 1 | Starts a group mode request when the sequencer is idle |
| req_mode | input | 4 | Mode value to apply |
| req_pads | input | LIST_MAX*IDX_W | Packed pad indices, entry 0 in the low bits |
| req_cnt | input | CNT_W | Number of list entries used |
| req_busy | output | 1 | Sequencer is handling a request |
| req_done | output | 1 | One-cycle completion pulse |
| req_accepted | output | 1 | High with req_done when the request was applied |

## Verification
For every pad, the bench steps through four ownership and lock states: clean, owned by another agent, full-locked and transmit-locked. This shows whether each of the three gating conditions blocks writes on its own, and whether the right pad's bit in the shared words is the one decoded. Group requests are tried with these cases:
- all pads usable
- a blocked pad first, in the middle, or last in the list
- an out-of-range index
- an oversize count
- an empty list
- a request raised while busy

Comparing done latency against each case's expected cycle count shows where the check stopped. Starting from all-ones configuration words separates the mode-field rewrite from the extra GPIO side effects.

// File: rtl/pag_pkg.sv
package pag_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_APPLY, ST_DONE} grp_state_e;

   localparam int unsigned MODE_LSB  = 10;
   localparam int unsigned MODE_W    = 4;
   localparam int unsigned ROUTE_LSB = 17;
   localparam int unsigned ROUTE_W   = 4;
   localparam int unsigned RXOFF_BIT = 9;
   localparam int unsigned TXOFF_BIT = 8;
   localparam int unsigned ADDR_W    = 12;

   localparam logic [ADDR_W-1:0] OWN_BASE  = 12'h100;
   localparam logic [ADDR_W-1:0] HOST_BASE = 12'h200;
   localparam logic [ADDR_W-1:0] LOCK_BASE = 12'h300;
   localparam logic [ADDR_W-1:0] PAD_BASE  = 12'h400;

   // New first config word after a mode change; mode 0 also forces input GPIO.
   function automatic logic [31:0] mode_update(input logic [31:0] cur,
                                               input logic [MODE_W-1:0] mode);
      logic [31:0] v;
      v = cur;
      v[MODE_LSB +: MODE_W] = mode;
      if (mode == '0) begin
         v[ROUTE_LSB +: ROUTE_W] = '0;
         v[RXOFF_BIT] = 1'b0;
         v[TXOFF_BIT] = 1'b1;
      end
      return v;
   endfunction
endpackage

// File: rtl/pag_own_lock.sv
module pag_own_lock
   import pag_pkg::*;
#(
   parameter int unsigned NUM_PADS = 24,
   parameter int unsigned GRP_PADS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [31:0]         rd_data,
   output logic [NUM_PADS-1:0] usable
);
   localparam int unsigned OWNER_W = 4;

   logic [OWNER_W-1:0] own_q [NUM_PADS];
   logic               host_q [NUM_PADS];
   logic               lkf_q [NUM_PADS];
   logic               lkt_q [NUM_PADS];

   function automatic logic [ADDR_W-1:0] own_addr(input int p);
      return OWN_BASE + ADDR_W'((p / GRP_PADS) * 16 + ((p % GRP_PADS) / 8) * 4);
   endfunction
   function automatic logic [ADDR_W-1:0] host_addr(input int p);
      return HOST_BASE + ADDR_W'((p / GRP_PADS) * 4);
   endfunction
   function automatic logic [ADDR_W-1:0] lock_addr(input int p);
      return LOCK_BASE + ADDR_W'((p / GRP_PADS) * 8);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PADS; p++) begin
            own_q[p]  <= '0;
            host_q[p] <= 1'b0;
            lkf_q[p]  <= 1'b0;
            lkt_q[p]  <= 1'b0;
         end
      end else if (bus_we) begin
         for (int p = 0; p < NUM_PADS; p++) begin
            if (bus_addr == own_addr(p))
               own_q[p] <= bus_wdata[OWNER_W*(p % 8) +: OWNER_W];
            if (bus_addr == host_addr(p))
               host_q[p] <= bus_wdata[p % GRP_PADS];
            if (bus_addr == lock_addr(p))
               lkf_q[p] <= bus_wdata[p % GRP_PADS];
            if (bus_addr == lock_addr(p) + ADDR_W'(4))
               lkt_q[p] <= bus_wdata[p % GRP_PADS];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NUM_PADS; p++) begin
         if (rd_addr == own_addr(p))
            rd_data[OWNER_W*(p % 8) +: OWNER_W] = own_q[p];
         if (rd_addr == host_addr(p))
            rd_data[p % GRP_PADS] = host_q[p];
         if (rd_addr == lock_addr(p))
            rd_data[p % GRP_PADS] = lkf_q[p];
         if (rd_addr == lock_addr(p) + ADDR_W'(4))
            rd_data[p % GRP_PADS] = lkt_q[p];
      end
   end

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_use
      assign usable[i] = (own_q[i] == '0) && !lkf_q[i] && !lkt_q[i];

      AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == lock_addr(i) && bus_wdata[i % GRP_PADS])
         |=> !usable[i]); // R3
   end
endmodule

// File: rtl/pag_pad_cfg.sv
module pag_pad_cfg
   import pag_pkg::*;
#(
   parameter int unsigned NUM_PADS = 24,
   parameter int unsigned IDX_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [31:0]         rd_data,
   input  logic [NUM_PADS-1:0] usable,
   input  logic                app_en,
   input  logic [IDX_W-1:0]    app_pad,
   input  logic [MODE_W-1:0]   app_mode,
   output logic                err
);
   logic [31:0] cfg0_q [NUM_PADS];
   logic [31:0] cfg1_q [NUM_PADS];
   logic        bad_hit;

   function automatic logic [ADDR_W-1:0] cfg_addr(input int p, input int w);
      return PAD_BASE + ADDR_W'(p * 8 + w * 4);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PADS; p++) begin
            cfg0_q[p] <= '0;
            cfg1_q[p] <= '0;
         end
      end else begin
         for (int p = 0; p < NUM_PADS; p++) begin
            // Sequencer update takes priority over a bus write in the same cycle.
            if (app_en && app_pad == IDX_W'(p))
               cfg0_q[p] <= mode_update(cfg0_q[p], app_mode);
            else if (bus_we && usable[p] && bus_addr == cfg_addr(p, 0))
               cfg0_q[p] <= bus_wdata;
            if (bus_we && usable[p] && bus_addr == cfg_addr(p, 1))
               cfg1_q[p] <= bus_wdata;
         end
      end
   end

   always_comb begin
      bad_hit = 1'b0;
      for (int p = 0; p < NUM_PADS; p++)
         if (bus_we && !usable[p] &&
             (bus_addr == cfg_addr(p, 0) || bus_addr == cfg_addr(p, 1)))
            bad_hit = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else        err <= bad_hit;
   end

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NUM_PADS; p++) begin
         if (rd_addr == cfg_addr(p, 0)) rd_data = cfg0_q[p];
         if (rd_addr == cfg_addr(p, 1)) rd_data = cfg1_q[p];
      end
   end

   AST_ERR_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(bus_we)); // R5

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_guard
      AST_CFG_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
         (!usable[i] && !(app_en && app_pad == IDX_W'(i)))
         |=> ($stable(cfg0_q[i]) && $stable(cfg1_q[i]))); // R5
   end
endmodule

// File: rtl/pag_group_fsm.sv
module pag_group_fsm
   import pag_pkg::*;
#(
   parameter int unsigned NUM_PADS = 24,
   parameter int unsigned LIST_MAX = 4,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned CNT_W    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [MODE_W-1:0]         req_mode,
   input  logic [LIST_MAX*IDX_W-1:0] req_pads,
   input  logic [CNT_W-1:0]          req_cnt,
   input  logic [NUM_PADS-1:0]       usable,
   output logic                      busy,
   output logic                      done,
   output logic                      accepted,
   output logic                      app_en,
   output logic [IDX_W-1:0]          app_pad,
   output logic [MODE_W-1:0]         app_mode
);
   localparam int unsigned IDX_SPAN = 1 << IDX_W;

   grp_state_e                state_q;
   logic [LIST_MAX*IDX_W-1:0] list_q;
   logic [CNT_W-1:0]          cnt_q, pos_q;
   logic [MODE_W-1:0]         mode_q;
   logic                      acc_q;
   logic [IDX_W-1:0]          cur_pad;
   logic [IDX_SPAN-1:0]       usable_x;
   logic                      pad_ok, last;

   always_comb begin
      cur_pad = '0;
      for (int k = 0; k < LIST_MAX; k++)
         if (pos_q == CNT_W'(k)) cur_pad = list_q[k*IDX_W +: IDX_W];
   end

   // Indices past the last pad read as unusable.
   always_comb begin
      usable_x = '0;
      usable_x[NUM_PADS-1:0] = usable;
   end

   assign pad_ok = usable_x[cur_pad];
   assign last   = (pos_q == cnt_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         list_q  <= '0;
         cnt_q   <= '0;
         pos_q   <= '0;
         mode_q  <= '0;
         acc_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               list_q <= req_pads;
               cnt_q  <= req_cnt;
               mode_q <= req_mode;
               pos_q  <= '0;
               if (req_cnt == '0) begin
                  acc_q   <= 1'b1;
                  state_q <= ST_DONE;
               end else if (req_cnt > CNT_W'(LIST_MAX)) begin
                  acc_q   <= 1'b0;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!pad_ok) begin
                  acc_q   <= 1'b0;
                  state_q <= ST_DONE;
               end else if (last) begin
                  pos_q   <= '0;
                  state_q <= ST_APPLY;
               end else begin
                  pos_q <= pos_q + CNT_W'(1);
               end
            end
            ST_APPLY: begin
               if (last) begin
                  acc_q   <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  pos_q <= pos_q + CNT_W'(1);
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);
   assign accepted = done && acc_q;
   assign app_en   = (state_q == ST_APPLY);
   assign app_pad  = cur_pad;
   assign app_mode = mode_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R9
   AST_REJECT_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHECK && !pad_ok) |=> (done && !accepted)); // R6
   AST_APPLY_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(app_en) |-> $past(state_q) == ST_CHECK); // R7
   AST_APPLY_USABLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(app_en) |-> $past(pad_ok)); // R6
endmodule

// File: rtl/pad_access_gate.sv
module pad_access_gate
   import pag_pkg::*;
#(
   parameter int unsigned NUM_PADS = 24,
   parameter int unsigned GRP_PADS = 16,
   parameter int unsigned LIST_MAX = 4,
   localparam int unsigned IDX_W   = $clog2(NUM_PADS),
   localparam int unsigned CNT_W   = $clog2(LIST_MAX + 1),
   localparam int unsigned NUM_GRP = (NUM_PADS + GRP_PADS - 1) / GRP_PADS
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_we,
   input  logic [11:0]               bus_addr,
   input  logic [31:0]               bus_wdata,
   input  logic [11:0]               rd_addr,
   output logic [31:0]               rd_data,
   output logic                      cfg_err,
   output logic [NUM_PADS-1:0]       pad_usable,
   input  logic                      req_valid,
   input  logic [3:0]                req_mode,
   input  logic [LIST_MAX*IDX_W-1:0] req_pads,
   input  logic [CNT_W-1:0]          req_cnt,
   output logic                      req_busy,
   output logic                      req_done,
   output logic                      req_accepted
);
   initial begin
      assert (NUM_PADS >= 2 && NUM_PADS <= 128) else $error("NUM_PADS out of range");
      assert (GRP_PADS % 8 == 0 && GRP_PADS >= 8 && GRP_PADS <= 32)
         else $error("GRP_PADS must be 8, 16, 24 or 32");
      assert (NUM_GRP <= 16) else $error("too many groups for the owner window");
      assert (LIST_MAX >= 1 && LIST_MAX <= 16) else $error("LIST_MAX out of range");
   end

   logic [31:0]       own_rd, cfg_rd;
   logic              app_en;
   logic [IDX_W-1:0]  app_pad;
   logic [MODE_W-1:0] app_mode;

   pag_own_lock #(.NUM_PADS(NUM_PADS), .GRP_PADS(GRP_PADS)) i_own_lock (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(own_rd),
      .usable(pad_usable));

   pag_pad_cfg #(.NUM_PADS(NUM_PADS), .IDX_W(IDX_W)) i_pad_cfg (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(cfg_rd),
      .usable(pad_usable), .app_en(app_en), .app_pad(app_pad),
      .app_mode(app_mode), .err(cfg_err));

   pag_group_fsm #(.NUM_PADS(NUM_PADS), .LIST_MAX(LIST_MAX), .IDX_W(IDX_W),
                   .CNT_W(CNT_W)) i_group_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_pads(req_pads), .req_cnt(req_cnt), .usable(pad_usable),
      .busy(req_busy), .done(req_done), .accepted(req_accepted),
      .app_en(app_en), .app_pad(app_pad), .app_mode(app_mode));

   assign rd_data = own_rd | cfg_rd;
endmodule

// File: tb/test_pad_access_gate.sv
module test_pad_access_gate;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 24;
   localparam int GP = 16;
   localparam int LM = 4;
   localparam int IW = 5;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [11:0]   rd_addr = '0;
   logic [31:0]   rd_data;
   logic          cfg_err;
   logic [NP-1:0] pad_usable;
   logic          req_valid = 1'b0;
   logic [3:0]    req_mode = '0;
   logic [LM*IW-1:0] req_pads = '0;
   logic [CW-1:0] req_cnt = '0;
   logic          req_busy, req_done, req_accepted;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [3:0]  m_own [NP];
   logic        m_lf [NP];
   logic        m_lt [NP];
   logic [31:0] m_c0 [NP];
   logic [31:0] m_c1 [NP];

   pad_access_gate i_pad_access_gate (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .cfg_err(cfg_err), .pad_usable(pad_usable), .req_valid(req_valid),
      .req_mode(req_mode), .req_pads(req_pads), .req_cnt(req_cnt),
      .req_busy(req_busy), .req_done(req_done), .req_accepted(req_accepted));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] a_own(int p);
      return 12'(32'h100 + 16*(p/GP) + 4*((p%GP)/8));
   endfunction
   function automatic logic [11:0] a_lock(int p);
      return 12'(32'h300 + 8*(p/GP));
   endfunction
   function automatic logic [11:0] a_cfg(int p, int w);
      return 12'(32'h400 + 8*p + 4*w);
   endfunction
   function automatic bit m_usable(int p);
      return (m_own[p] == 0) && !m_lf[p] && !m_lt[p];
   endfunction
   function automatic logic [31:0] m_mode(logic [31:0] c, logic [3:0] m);
      logic [31:0] v;
      v = (c & ~(32'hF << 10)) | (32'(m) << 10);
      if (m == 0) v = (v & ~(32'hF << 17) & ~(32'h1 << 9)) | (32'h1 << 8);
      return v;
   endfunction

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, output bit e);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      e = cfg_err;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic push_owner(input int p);
      logic [31:0] d; bit e;
      d = '0;
      for (int q = 0; q < NP; q++)
         if (a_own(q) == a_own(p)) d[4*(q%8) +: 4] = m_own[q];
      bus_wr(a_own(p), d, e);
   endtask

   task automatic push_locks(input int p);
      logic [31:0] df, dt; bit e;
      df = '0; dt = '0;
      for (int q = 0; q < NP; q++)
         if (q / GP == p / GP) begin
            df[q%GP] = m_lf[q];
            dt[q%GP] = m_lt[q];
         end
      bus_wr(a_lock(p), df, e);
      bus_wr(a_lock(p) + 12'd4, dt, e);
   endtask

   task automatic check_all_cfg0(input string tag);
      logic [31:0] d;
      for (int p = 0; p < NP; p++) begin
         rd(a_cfg(p, 0), d);
         chk(d == m_c0[p], tag, d, m_c0[p]);
      end
   endtask

   task automatic grp_req(input int n, input int p0, input int p1, input int p2,
                          input int p3, input logic [3:0] mode, input bit exp_acc,
                          input int exp_cyc, input string tag);
      int pl [4];
      int cyc;
      pl = '{p0, p1, p2, p3};
      @(negedge clk);
      for (int i = 0; i < LM; i++) req_pads[i*IW +: IW] = IW'(pl[i]);
      req_cnt = CW'(n); req_mode = mode; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!req_done && cyc < 50) begin
         @(negedge clk);
         cyc++;
      end
      chk(req_accepted == exp_acc, {tag, " accept"}, 32'(req_accepted), 32'(exp_acc));
      chk(cyc == exp_cyc, "R10 done latency", 32'(cyc), 32'(exp_cyc));
      @(negedge clk);
      chk(req_done == 1'b0, "R9 done single cycle", 32'(req_done), 0);
      if (exp_acc)
         for (int i = 0; i < n && i < LM; i++) m_c0[pl[i]] = m_mode(m_c0[pl[i]], mode);
      check_all_cfg0(tag);
   endtask

   initial begin
      logic [31:0] d;
      bit e;
      for (int p = 0; p < NP; p++) begin
         m_own[p] = 0; m_lf[p] = 0; m_lt[p] = 0; m_c0[p] = 0; m_c1[p] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3: reset state
      chk(pad_usable == '1, "R3 reset usable", 32'(pad_usable), 32'hFFFFFF);
      chk(req_done == 0 && req_busy == 0, "R3 reset sequencer idle", 32'(req_busy), 0);
      for (int p = 0; p < NP; p++) begin
         rd(a_cfg(p, 1), d);
         chk(d == 0, "R3 reset cfg1", d, 0);
      end
      check_all_cfg0("R3 reset cfg0");

      // R2: host-mode word reads back and does not alter usability
      bus_wr(12'h200, 32'h0000_A5C3, e);
      rd(12'h200, d);
      chk(d == 32'h0000_A5C3, "R2 host word group0", d, 32'h0000_A5C3);
      bus_wr(12'h204, 32'h0000_00FF, e);
      rd(12'h204, d);
      chk(d == 32'h0000_00FF, "R2 host word group1", d, 32'h0000_00FF);
      chk(pad_usable == '1, "R2 host bit no effect on usable", 32'(pad_usable), 32'hFFFFFF);

      // R1 R3 R4 R5: sweep every pad through four ownership/lock states
      for (int p = 0; p < NP; p++) begin
         for (int s = 0; s < 4; s++) begin
            logic [31:0] pat;
            m_own[p] = (s == 1) ? 4'((p % 15) + 1) : 4'd0;
            m_lf[p]  = (s == 2);
            m_lt[p]  = (s == 3);
            push_owner(p);
            push_locks(p);
            rd(a_own(p), d);
            chk(d[4*(p%8) +: 4] == m_own[p], "R1 owner field",
                32'(d[4*(p%8) +: 4]), 32'(m_own[p]));
            rd(a_lock(p), d);
            chk(d[p%GP] == m_lf[p], "R2 full lock bit", 32'(d[p%GP]), 32'(m_lf[p]));
            rd(a_lock(p) + 12'd4, d);
            chk(d[p%GP] == m_lt[p], "R2 transmit lock bit", 32'(d[p%GP]), 32'(m_lt[p]));
            chk(pad_usable[p] == m_usable(p), "R3 usable flag",
                32'(pad_usable[p]), 32'(m_usable(p)));
            pat = 32'hA500_0000 ^ 32'(p << 4) ^ 32'(s);
            bus_wr(a_cfg(p, 0), pat, e);
            chk(e == !m_usable(p), "R5 error pulse", 32'(e), 32'(!m_usable(p)));
            @(negedge clk);
            chk(cfg_err == 0, "R5 error lasts one cycle", 32'(cfg_err), 0);
            if (m_usable(p)) m_c0[p] = pat;
            rd(a_cfg(p, 0), d);
            chk(d == m_c0[p], "R4 cfg0 write/read", d, m_c0[p]);
            bus_wr(a_cfg(p, 1), ~pat, e);
            if (m_usable(p)) m_c1[p] = ~pat;
            rd(a_cfg(p, 1), d);
            chk(d == m_c1[p], "R5 cfg1 guarded", d, m_c1[p]);
         end
         m_lt[p] = 0;
         push_locks(p);
      end

      // R7: accepted request on all-ones words keeps non-mode bits
      foreach (m_c0[p]) begin
         if (p == 0 || p == 5 || p == 17 || p == 23) begin
            m_c0[p] = 32'hFFFF_FFFF;
            bus_wr(a_cfg(p, 0), 32'hFFFF_FFFF, e);
         end
      end
      grp_req(4, 0, 5, 17, 23, 4'd5, 1'b1, 8, "R7 accept four pads");

      // R6: blocked pad in the middle (full lock) rejects with no change
      m_lf[17] = 1; push_locks(17);
      grp_req(3, 3, 17, 4, 0, 4'd9, 1'b0, 2, "R6 reject locked middle");
      m_lf[17] = 0; push_locks(17);

      // R6: foreign owner on second entry
      m_own[4] = 4'd3; push_owner(4);
      grp_req(2, 2, 4, 0, 0, 4'd9, 1'b0, 2, "R6 reject foreign owner");
      m_own[4] = 0; push_owner(4);

      // R6: transmit lock on the last entry only
      m_lt[20] = 1; push_locks(20);
      grp_req(4, 1, 2, 3, 20, 4'd6, 1'b0, 4, "R6 reject last entry");
      m_lt[20] = 0; push_locks(20);

      // R6: index past the last pad
      grp_req(2, 6, 30, 0, 0, 4'd2, 1'b0, 2, "R6 reject out of range");

      // R6: count above list capacity
      grp_req(5, 1, 2, 3, 4, 4'd7, 1'b0, 0, "R6 reject oversize count");

      // R8: GPIO selection side effects on all-ones words
      grp_req(2, 0, 23, 0, 0, 4'd0, 1'b1, 4, "R8 gpio select");

      // R9: empty list accepted without change
      grp_req(0, 1, 2, 3, 4, 4'd11, 1'b1, 0, "R9 empty list");

      // R9: request while busy is ignored
      @(negedge clk);
      req_pads = '0;
      req_pads[0 +: IW] = IW'(6); req_pads[IW +: IW] = IW'(7);
      req_cnt = CW'(2); req_mode = 4'd3; req_valid = 1'b1;
      @(negedge clk);
      req_pads[0 +: IW] = IW'(8); req_cnt = CW'(1); req_mode = 4'd12;
      @(negedge clk);
      chk(req_busy == 1, "R9 busy during request", 32'(req_busy), 1);
      req_valid = 1'b0;
      for (int k = 0; k < 20 && !req_done; k++) @(negedge clk);
      chk(req_accepted == 1, "R9 first request accepted", 32'(req_accepted), 1);
      repeat (4) @(negedge clk);
      chk(req_busy == 0, "R9 second request not started", 32'(req_busy), 0);
      m_c0[6] = m_mode(m_c0[6], 4'd3);
      m_c0[7] = m_mode(m_c0[7], 4'd3);
      check_all_cfg0("R9 busy request ignored");

      summary();
   end
endmodule